// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block sits beside the datapath of a two-input floating-point unit and decides the result whenever at least one operand is a NaN. It receives both raw operands in one binary interchange format (sign, biased exponent, fraction with a hidden bit) and classifies each one as a quiet NaN, a signaling NaN or a non-NaN. A fraction MSB of one marks a quiet NaN. One of four propagation policies then chooses which operand becomes the result. A chosen signaling NaN is turned quiet, the invalid-operation flag is raised for any signaling input, and a default-NaN mode can replace the chosen NaN with a fixed pattern.

Every result is registered. Each `in_valid` pulse produces a matching `out_valid` one clock later, together with the result encoding, an index that tells which source was used, the invalid flag and an indication that neither input was a NaN. The non-NaN result of the arithmetic is computed elsewhere. When `out_no_nan` is high, `out_res` has no meaning.

Top module: `nan_prop_sel`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. After synchronous reset `out_valid`, `out_invalid` and `out_no_nan` are low.
- R2: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. It is quiet when fraction bit FRAC_W-1 is one and signaling otherwise. An infinity (all-ones exponent, zero fraction) is not a NaN. `out_no_nan` is high exactly when neither operand is a NaN.
- R3: With policy 0, the result is the first match in this list: a if signaling, b if signaling, a if quiet, otherwise b.
- R4: With policy 1, the result is a when a is any NaN and b otherwise.
- R5: With policy 2 and `use_first` high, the result is a if a is a NaN and b otherwise. With `use_first` low, the result is b if b is a NaN and a otherwise.
- R6: With policy 3, a signaling NaN paired with a quiet NaN yields the quiet one, and a NaN paired with a non-NaN yields the NaN. Two NaNs of the same kind yield the one with the larger significand.
- R7: Under policy 3, when the two fractions are equal, a counts as larger only if a is positive and b is negative. Otherwise b is chosen.
- R8: A chosen signaling NaN leaves the block with fraction bit FRAC_W-1 set and all other bits unchanged. A chosen quiet NaN passes through unchanged.
- R9: `out_invalid` is high when either operand is a signaling NaN, also in default-NaN mode.
- R10: With `dnan_en` high and at least one NaN input, the result is the default NaN: sign 1, exponent all ones, only fraction bit FRAC_W-1 set. `out_sel` is then 3.
- R11: When the result comes from an operand, `out_sel` is 0 for operand a and 1 for operand b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 1+EXP_W+FRAC_W | First operand, raw encoding |
| op_b | input | 1+EXP_W+FRAC_W | Second operand, raw encoding |
| policy | input | 2 | Propagation policy 0..3 |
| use_first | input | 1 | Order choice for policy 2 |
| dnan_en | input | 1 | Replace a NaN result with the default NaN |
| out_valid | output | 1 | Registered outputs are valid |
| out_res | output | 1+EXP_W+FRAC_W | Result encoding (meaningless when out_no_nan) |
| out_sel | output | 2 | Source: 0 = a, 1 = b, 3 = default NaN |
| out_invalid | output | 1 | Either input was a signaling NaN |
| out_no_nan | output | 1 | Neither input was a NaN |

## Verification
The hardest cases to reach are the policy 3 tie-breaks. Both operands must be NaNs of the same kind with identical fractions, and only the signs differ. The stimulus table holds operand pairs built for this: equal-fraction quiet NaNs with opposite signs in both orders, and a pair with equal signs, where `out_sel` alone shows the choice. Signaling NaNs whose fractions differ only in low bits cover the magnitude rule and the silencing together. A default-NaN case with a signaling input shows that the flag survives the override.

// File: rtl/nan_prop_pkg.sv
package nan_prop_pkg;
  typedef enum logic [1:0] {
    POL_SNAN_FIRST = 2'd0,
    POL_FIRST_NAN  = 2'd1,
    POL_ORDERED    = 2'd2,
    POL_MAGNITUDE  = 2'd3
  } policy_e;

  localparam logic [1:0] SEL_A    = 2'd0;
  localparam logic [1:0] SEL_B    = 2'd1;
  localparam logic [1:0] SEL_DNAN = 2'd3;
endpackage

// File: rtl/nan_class.sv
module nan_class #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] val,
  output logic                  is_nan,
  output logic                  is_snan
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f   = val[FRAC_W +: EXP_W];
  assign frac_f  = val[FRAC_W-1:0];
  assign is_nan  = (&exp_f) && (|frac_f);
  assign is_snan = is_nan && !frac_f[FRAC_W-1];
endmodule

// File: rtl/nan_pick.sv
module nan_pick
  import nan_prop_pkg::*;
#(
  parameter int FRAC_W = 23
) (
  input  logic              a_nan,
  input  logic              a_snan,
  input  logic              b_nan,
  input  logic              b_snan,
  input  logic [FRAC_W-1:0] a_frac,
  input  logic [FRAC_W-1:0] b_frac,
  input  logic              a_sign,
  input  logic              b_sign,
  input  logic [1:0]        policy,
  input  logic              use_first,
  output logic              pick_b
);
  logic    a_qnan, b_qnan, a_larger;
  policy_e pol;

  assign pol    = policy_e'(policy);
  assign a_qnan = a_nan && !a_snan;
  assign b_qnan = b_nan && !b_snan;

  // magnitude order with sign as the final tie-break
  always_comb begin
    if (a_frac > b_frac)      a_larger = 1'b1;
    else if (a_frac < b_frac) a_larger = 1'b0;
    else                      a_larger = !a_sign && b_sign;
  end

  always_comb begin
    pick_b = 1'b0;
    unique case (pol)
      POL_SNAN_FIRST: begin
        if (a_snan)      pick_b = 1'b0;
        else if (b_snan) pick_b = 1'b1;
        else if (a_qnan) pick_b = 1'b0;
        else             pick_b = 1'b1;
      end
      POL_FIRST_NAN: pick_b = !a_nan;
      POL_ORDERED: begin
        if (use_first) pick_b = !a_nan;
        else           pick_b = b_nan;
      end
      POL_MAGNITUDE: begin
        if (a_snan) begin
          if (b_snan)      pick_b = !a_larger;
          else if (b_qnan) pick_b = 1'b1;
          else             pick_b = 1'b0;
        end else if (a_qnan) begin
          if (b_qnan) pick_b = !a_larger;
          else        pick_b = 1'b0;
        end else begin
          pick_b = 1'b1;
        end
      end
      default: pick_b = 1'b0;
    endcase
  end
endmodule

// File: rtl/nan_quiet.sv
module nan_quiet #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] val,
  input  logic                  make_quiet,
  output logic [EXP_W+FRAC_W:0] val_q
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QBIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

  assign val_q = make_quiet ? (val | QBIT) : val;
endmodule

// File: rtl/nan_prop_sel.sv
module nan_prop_sel
  import nan_prop_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [EXP_W+FRAC_W:0]   op_a,
  input  logic [EXP_W+FRAC_W:0]   op_b,
  input  logic [1:0]              policy,
  input  logic                    use_first,
  input  logic                    dnan_en,
  output logic                    out_valid,
  output logic [EXP_W+FRAC_W:0]   out_res,
  output logic [1:0]              out_sel,
  output logic                    out_invalid,
  output logic                    out_no_nan
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] DEF_NAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] ops [2];
  logic [1:0]   nan_v, snan_v;
  logic         pick_b, chosen_sn, any_nan;
  logic [W-1:0] chosen, chosen_q, res_d;
  logic [1:0]   sel_d;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    nan_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .val     (ops[i]),
      .is_nan  (nan_v[i]),
      .is_snan (snan_v[i])
    );
  end

  nan_pick #(.FRAC_W(FRAC_W)) u_pick (
    .a_nan     (nan_v[0]),
    .a_snan    (snan_v[0]),
    .b_nan     (nan_v[1]),
    .b_snan    (snan_v[1]),
    .a_frac    (op_a[FRAC_W-1:0]),
    .b_frac    (op_b[FRAC_W-1:0]),
    .a_sign    (op_a[W-1]),
    .b_sign    (op_b[W-1]),
    .policy    (policy),
    .use_first (use_first),
    .pick_b    (pick_b)
  );

  assign chosen    = pick_b ? op_b : op_a;
  assign chosen_sn = pick_b ? snan_v[1] : snan_v[0];
  assign any_nan   = |nan_v;

  nan_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
    .val        (chosen),
    .make_quiet (chosen_sn),
    .val_q      (chosen_q)
  );

  always_comb begin
    if (!any_nan) begin
      res_d = op_a;
      sel_d = SEL_A;
    end else if (dnan_en) begin
      res_d = DEF_NAN;
      sel_d = SEL_DNAN;
    end else begin
      res_d = chosen_q;
      sel_d = pick_b ? SEL_B : SEL_A;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_res     <= '0;
      out_sel     <= SEL_A;
      out_invalid <= 1'b0;
      out_no_nan  <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid && (|snan_v);
      out_no_nan  <= in_valid && !any_nan;
      if (in_valid) begin
        out_res <= res_d;
        out_sel <= sel_d;
      end
    end
  end
endmodule

// File: rtl/nan_prop_sel_chk.sv
module nan_prop_sel_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  dnan_en,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] out_res,
  input logic [1:0]            out_sel,
  input logic                  out_invalid,
  input logic                  out_no_nan
);
  localparam int W = 1 + EXP_W + FRAC_W;
  localparam logic [W-1:0] QBIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [W-1:0] DNAN = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic a_isn, b_isn, a_sig, b_sig;
  assign a_isn = (&op_a[FRAC_W +: EXP_W]) && (|op_a[FRAC_W-1:0]);
  assign b_isn = (&op_b[FRAC_W +: EXP_W]) && (|op_b[FRAC_W-1:0]);
  assign a_sig = a_isn && !op_a[FRAC_W-1];
  assign b_sig = b_isn && !op_b[FRAC_W-1];

  // R1
  valid_origin_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  no_nan_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_no_nan == !($past(a_isn) || $past(b_isn))));
  // R9
  invalid_flag_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_invalid == ($past(a_sig) || $past(b_sig))));
  // R8
  quiet_result_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_no_nan) |-> (out_res[FRAC_W-1] && (&out_res[FRAC_W +: EXP_W])));
  // R10
  default_nan_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_no_nan && $past(dnan_en)) |-> (out_sel == 2'd3 && out_res == DNAN));
  // R11
  source_a_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sel == 2'd0) |-> ((out_res | QBIT) == ($past(op_a) | QBIT)));
  // R11
  source_b_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sel == 2'd1) |-> ((out_res | QBIT) == ($past(op_b) | QBIT)));
endmodule

bind nan_prop_sel nan_prop_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .op_a        (op_a),
  .op_b        (op_b),
  .dnan_en     (dnan_en),
  .out_valid   (out_valid),
  .out_res     (out_res),
  .out_sel     (out_sel),
  .out_invalid (out_invalid),
  .out_no_nan  (out_no_nan)
);

// File: tb/nan_prop_sel_test.sv
`timescale 1ns/1ps
module nan_prop_sel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  policy = '0;
  logic        use_first = 1'b0, dnan_en = 1'b0;
  logic        out_valid, out_invalid, out_no_nan;
  logic [31:0] out_res;
  logic [1:0]  out_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nan_prop_sel uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .policy(policy), .use_first(use_first), .dnan_en(dnan_en),
    .out_valid(out_valid), .out_res(out_res), .out_sel(out_sel),
    .out_invalid(out_invalid), .out_no_nan(out_no_nan)
  );

  typedef struct packed {
    logic [1:0]  pol;
    logic        uf;
    logic        dn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [1:0]  sel;
    logic        inv;
    logic [3:0]  req;
  } vec_t;

  localparam logic [31:0] QA  = 32'h7FC0_0001;
  localparam logic [31:0] QB  = 32'hFFC0_0002;
  localparam logic [31:0] SA  = 32'h7F80_0005;
  localparam logic [31:0] SB  = 32'h7F80_0009;
  localparam logic [31:0] SAQ = 32'h7FC0_0005;
  localparam logic [31:0] SBQ = 32'h7FC0_0009;
  localparam logic [31:0] ONE = 32'h3F80_0000;
  localparam logic [31:0] INF = 32'h7F80_0000;
  localparam logic [31:0] DN  = 32'hFFC0_0000;
  localparam int NV = 20;

  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 1'b0, QA,  SB,  SBQ, 2'd1, 1'b1, 4'd3},   // R3 b signaling beats a quiet
    '{2'd0, 1'b0, 1'b0, SA,  SB,  SAQ, 2'd0, 1'b1, 4'd3},   // R3
    '{2'd0, 1'b0, 1'b0, ONE, QB,  QB,  2'd1, 1'b0, 4'd3},   // R3
    '{2'd0, 1'b0, 1'b0, QA,  QB,  QA,  2'd0, 1'b0, 4'd3},   // R3
    '{2'd1, 1'b0, 1'b0, QA,  SB,  QA,  2'd0, 1'b1, 4'd4},   // R4
    '{2'd1, 1'b0, 1'b0, ONE, SB,  SBQ, 2'd1, 1'b1, 4'd8},   // R8 silencing
    '{2'd2, 1'b1, 1'b0, QA,  QB,  QA,  2'd0, 1'b0, 4'd5},   // R5
    '{2'd2, 1'b0, 1'b0, QA,  QB,  QB,  2'd1, 1'b0, 4'd5},   // R5
    '{2'd2, 1'b0, 1'b0, SA,  ONE, SAQ, 2'd0, 1'b1, 4'd5},   // R5
    '{2'd3, 1'b0, 1'b0, SA,  QB,  QB,  2'd1, 1'b1, 4'd6},   // R6
    '{2'd3, 1'b0, 1'b0, QB,  SA,  QB,  2'd0, 1'b1, 4'd6},   // R6
    '{2'd3, 1'b0, 1'b0, SA,  SB,  SBQ, 2'd1, 1'b1, 4'd6},   // R6
    '{2'd3, 1'b0, 1'b0, QA,  QB,  QB,  2'd1, 1'b0, 4'd6},   // R6
    '{2'd3, 1'b0, 1'b0, ONE, SA,  SAQ, 2'd1, 1'b1, 4'd6},   // R6
    '{2'd3, 1'b0, 1'b0, 32'h7FC0_0003, 32'hFFC0_0003, 32'h7FC0_0003, 2'd0, 1'b0, 4'd7}, // R7
    '{2'd3, 1'b0, 1'b0, 32'hFFC0_0003, 32'h7FC0_0003, 32'h7FC0_0003, 2'd1, 1'b0, 4'd7}, // R7
    '{2'd3, 1'b0, 1'b0, 32'h7FC0_0003, 32'h7FC0_0003, 32'h7FC0_0003, 2'd1, 1'b0, 4'd7}, // R7
    '{2'd0, 1'b0, 1'b1, SA,  ONE, DN,  2'd3, 1'b1, 4'd9},   // R9 flag kept in default mode
    '{2'd1, 1'b0, 1'b1, QA,  QB,  DN,  2'd3, 1'b0, 4'd10},  // R10
    '{2'd1, 1'b0, 1'b0, INF, QB,  QB,  2'd1, 1'b0, 4'd2}    // R2 infinity is not a NaN
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] p, input logic uf, input logic dn,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = 1'b1; policy = p; use_first = uf; dnan_en = dn; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1", "out_invalid in reset", {31'd0, out_invalid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "out_valid idle", {31'd0, out_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string r;
      r = $sformatf("R%0d", VEC[i].req);
      drive(VEC[i].pol, VEC[i].uf, VEC[i].dn, VEC[i].a, VEC[i].b);
      check(r, "valid", {31'd0, out_valid}, 32'd1);
      check(r, "result", out_res, VEC[i].res);
      check(r, "sel", {30'd0, out_sel}, {30'd0, VEC[i].sel});
      check(r, "invalid", {31'd0, out_invalid}, {31'd0, VEC[i].inv});
      check(r, "no_nan", {31'd0, out_no_nan}, 32'd0);
    end

    // R1 valid drops one cycle after in_valid drops
    @(negedge clk);
    check("R1", "valid after idle", {31'd0, out_valid}, 32'd0);

    // R2 neither operand a NaN (number and infinity)
    drive(2'd3, 1'b0, 1'b1, ONE, INF);
    check("R2", "no_nan", {31'd0, out_no_nan}, 32'd1);
    check("R9", "invalid without NaN", {31'd0, out_invalid}, 32'd0);

    // R8 quiet chosen NaN passes unchanged under policy 1
    drive(2'd1, 1'b0, 1'b0, QB, SA);
    check("R8", "quiet passthrough", out_res, QB);
    check("R11", "sel a", {30'd0, out_sel}, 32'd0);

    // R9 both signaling, default mode off, policy 2 use_first
    drive(2'd2, 1'b1, 1'b0, SB, SA);
    check("R9", "invalid", {31'd0, out_invalid}, 32'd1);
    check("R8", "silenced a", out_res, SBQ);

    // R1 back-to-back inputs
    @(negedge clk);
    in_valid = 1'b1; policy = 2'd1; dnan_en = 1'b0; op_a = QA; op_b = QB;
    @(negedge clk);
    op_a = ONE; op_b = SB;
    check("R1", "first of pair", out_res, QA);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1", "second of pair", out_res, SBQ);
    check("R11", "second sel", {30'd0, out_sel}, 32'd1);

    // R1 synchronous reset clears valid
    @(negedge clk);
    in_valid = 1'b1; op_a = QA; rst = 1'b1;
    @(negedge clk);
    check("R1", "reset clears valid", {31'd0, out_valid}, 32'd0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule